// File: doc/BRIEF.md
# Dual-tone frequency decoder by period counting

This block sits behind the analog front end of a touch-tone receiver. It takes two full-swing square waves, one already limited from the low-frequency band and one from the high-frequency band, and works out which of the four standard tones of each band is present. It does this by counting reference-clock cycles between successive rising edges and summing the last four such periods. The sum is then compared against an acceptance window per standard tone.

When both bands carry an accepted tone at once, the block raises `early_steer` and drives the matching 4-bit key number on `digit_code`. The flag is momentary. It falls as soon as either band stops qualifying, and `digit_code` is only meaningful while the flag is high. Checking signal duration and holding the result belong to a separate steering block that watches `early_steer`.

Both square-wave inputs are treated as asynchronous. Each passes through a two-stage synchronizer before its edges are found. The clock frequency `CLK_HZ` is a parameter and sets every acceptance window.

Top module: `dtmf_count_decoder`

## Requirements
- R1: `early_steer` is high only when both the low band and the high band hold an accepted tone. A tone in one band alone keeps it low.
- R2: A band is accepted when the sum S of its last four periods falls inside an inclusive window for one of that band's nominal tones. A period is measured in clock cycles from rising edge to rising edge. Low-band tones, index 0 to 3, are 697, 770, 852 and 941 Hz. High-band tones, index 0 to 3, are 1209, 1336, 1477 and 1633 Hz. For a tone f, N = floor(4*CLK_HZ/f), and the window is floor(N*97/100) to floor(N*103/100).
- R3: A band is accepted only after four complete periods since its history was last cleared. Four rising edges, which make three periods, are not enough.
- R4: A gap of 2^PW-1 or more cycles without a rising edge rejects the band and discards its period history. When the low tone stops, `early_steer` falls within one low period plus 2^PW+8 cycles.
- R5: With r the low-band index and c the high-band index, `digit_code` follows the keypad grid. For rows 0 to 2 and c = 0 to 2 the code is 3r+c+1. For c = 3 the code is 13+r for rows 0 to 2, and 0 for row 3. On row 3, c = 0, 1 and 2 give 11, 10 and 12.
- R6: An input is first sampled high at clock edge k. The band decision that this rising edge completes is taken at edge k+2, and `early_steer` and `digit_code` follow at edge k+3.
- R7: When the four-period sum leaves every window, `early_steer` falls at the next update, without waiting for more periods.
- R8: Reset is synchronous and active high. It forces `early_steer` low, clears both period histories, and restarts timing, so that acceptance again needs four fresh periods.
- R9: The decision uses the four-period sum, not single periods. Alternating periods whose sum fits a window are accepted. Alternating periods whose sum fits no window are rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock of CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| low_tone | input | 1 | Limited low-band square wave, asynchronous |
| high_tone | input | 1 | Limited high-band square wave, asynchronous |
| early_steer | output | 1 | High while both bands hold accepted tones |
| digit_code | output | 4 | Key number of the detected tone pair, valid while early_steer is high |

## Verification
A corrupted period history or counter shows up at the ports within a few clock edges of the next rising input edge. It appears as a wrong key number, a flag that rises one period early or late, or a flag that stays up past a dropped tone. A reference model compares the flag and the key number on every clock edge, so any such slip is reported in the cycle it occurs. Directed cases sit on the window edges (a sum of exactly 320 against one of 340), on bursts of four and five rising edges, on the saturation gap, and on reset given in the middle of a tone.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int AVG_N      = 4;
    localparam int WIN_LO_PCT = 97;
    localparam int WIN_HI_PCT = 103;

    function automatic int tone_hz(input bit high_band, input int k);
        case ({high_band, k[1:0]})
            3'b000:  return 697;
            3'b001:  return 770;
            3'b010:  return 852;
            3'b011:  return 941;
            3'b100:  return 1209;
            3'b101:  return 1336;
            3'b110:  return 1477;
            default: return 1633;
        endcase
    endfunction

    function automatic int nominal_sum(input int clk_hz, input bit high_band, input int k);
        return (AVG_N * clk_hz) / tone_hz(high_band, k);
    endfunction

    function automatic int window_lo(input int clk_hz, input bit high_band, input int k);
        return (nominal_sum(clk_hz, high_band, k) * WIN_LO_PCT) / 100;
    endfunction

    function automatic int window_hi(input int clk_hz, input bit high_band, input int k);
        return (nominal_sum(clk_hz, high_band, k) * WIN_HI_PCT) / 100;
    endfunction

    function automatic logic [3:0] code_of(input logic [1:0] row, input logic [1:0] col);
        if (col == 2'd3)
            return (row == 2'd3) ? 4'd0 : 4'(13 + int'(row));
        if (row == 2'd3)
            return (col == 2'd0) ? 4'd11 : ((col == 2'd1) ? 4'd10 : 4'd12);
        return 4'(int'(row) * 3 + int'(col) + 1);
    endfunction

endpackage

// File: rtl/dtmf_edge_detect.sv
module dtmf_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic sq_in,
    output logic rise
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.s1   = sq_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.prev;

    // a detected edge lasts one cycle (R6)
    p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/dtmf_group_meter.sv
module dtmf_group_meter
    import dtmf_pkg::*;
#(
    parameter int CLK_HZ     = 100000,
    parameter int PW         = 8,
    parameter bit HIGH_GROUP = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    output logic       valid,
    output logic [1:0] idx
);

    localparam int FW = $clog2(AVG_N + 1);
    localparam int SW = PW + $clog2(AVG_N);
    localparam logic [PW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [PW-1:0]                cnt;
        logic [AVG_N-2:0][PW-1:0]     hist;
        logic [FW-1:0]                fill;
        logic                         valid;
        logic [1:0]                   idx;
    } meter_st_t;

    meter_st_t st_d, st_q;

    logic [SW-1:0] period_sum;
    logic [3:0]    hit;
    logic          saturated;

    assign saturated = (st_q.cnt == CNT_MAX);

    always_comb begin
        period_sum = SW'(st_q.cnt);
        for (int i = 0; i < AVG_N - 1; i++)
            period_sum = period_sum + SW'(st_q.hist[i]);
    end

    for (genvar k = 0; k < 4; k++) begin : g_window
        localparam int LO = window_lo(CLK_HZ, HIGH_GROUP, k);
        localparam int HI = window_hi(CLK_HZ, HIGH_GROUP, k);
        assign hit[k] = (period_sum >= SW'(LO)) && (period_sum <= SW'(HI));
    end

    always_comb begin
        logic [FW-1:0] fill_n;
        st_d   = st_q;
        fill_n = st_q.fill;
        if (rise) begin
            st_d.cnt = PW'(1);
            if (saturated) begin
                st_d.fill  = '0;
                st_d.valid = 1'b0;
            end else begin
                for (int i = AVG_N - 2; i > 0; i--)
                    st_d.hist[i] = st_q.hist[i-1];
                st_d.hist[0] = st_q.cnt;
                if (st_q.fill != FW'(AVG_N))
                    fill_n = st_q.fill + FW'(1);
                st_d.fill  = fill_n;
                st_d.valid = (fill_n == FW'(AVG_N)) && (|hit);
                for (int k = 3; k >= 0; k--)
                    if (hit[k]) st_d.idx = 2'(k);
            end
        end else if (saturated) begin
            st_d.fill  = '0;
            st_d.valid = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.cnt   <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign idx   = st_q.idx;

    p_valid_needs_full_r3: assert property (@(posedge clk) disable iff (rst)
        valid |-> (st_q.fill == FW'(AVG_N)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (saturated && !rise) |=> (!valid && st_q.fill == '0));

    p_hold_between_edges_r2: assert property (@(posedge clk) disable iff (rst)
        (!rise && !saturated) |=> ($stable(valid) && $stable(idx)));

endmodule

// File: rtl/dtmf_count_decoder.sv
module dtmf_count_decoder
    import dtmf_pkg::*;
#(
    parameter int CLK_HZ = 100000,
    parameter int PW     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       low_tone,
    input  logic       high_tone,
    output logic       early_steer,
    output logic [3:0] digit_code
);

    typedef struct packed {
        logic       steer;
        logic [3:0] code;
    } top_st_t;

    top_st_t st_d, st_q;

    logic       lo_rise, hi_rise;
    logic       lo_valid, hi_valid;
    logic [1:0] lo_idx, hi_idx;

    dtmf_edge_detect u_lo_edge (.clk(clk), .rst(rst), .sq_in(low_tone),  .rise(lo_rise));
    dtmf_edge_detect u_hi_edge (.clk(clk), .rst(rst), .sq_in(high_tone), .rise(hi_rise));

    dtmf_group_meter #(.CLK_HZ(CLK_HZ), .PW(PW), .HIGH_GROUP(1'b0)) u_lo_meter (
        .clk(clk), .rst(rst), .rise(lo_rise), .valid(lo_valid), .idx(lo_idx));

    dtmf_group_meter #(.CLK_HZ(CLK_HZ), .PW(PW), .HIGH_GROUP(1'b1)) u_hi_meter (
        .clk(clk), .rst(rst), .rise(hi_rise), .valid(hi_valid), .idx(hi_idx));

    always_comb begin
        st_d.steer = lo_valid & hi_valid;
        st_d.code  = code_of(lo_idx, hi_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign early_steer = st_q.steer;
    assign digit_code  = st_q.code;

    p_steer_needs_both_r1: assert property (@(posedge clk) disable iff (rst)
        early_steer |-> $past(lo_valid && hi_valid));

    p_steer_drops_r7: assert property (@(posedge clk) disable iff (rst)
        !(lo_valid && hi_valid) |=> !early_steer);

endmodule

// File: tb/dtmf_count_decoder_bench.sv
module dtmf_count_decoder_bench;

    localparam int CLK_HZ = 100000;
    localparam int PW     = 8;
    localparam int MAXC   = (1 << PW) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] tones = 2'b00;
    logic       early_steer;
    logic [3:0] digit_code;

    int n_tests = 0;
    int n_fail  = 0;

    dtmf_count_decoder #(.CLK_HZ(CLK_HZ), .PW(PW)) u_dtmf_count_decoder (
        .clk(clk), .rst(rst), .low_tone(tones[0]), .high_tone(tones[1]),
        .early_steer(early_steer), .digit_code(digit_code));

    always #10 clk = ~clk;

    // ---------------- stimulus generators (periods in cycles) ----------------
    int per_a[2] = '{0, 0};
    int per_b[2] = '{0, 0};
    int phase[2] = '{0, 0};
    bit use_b[2] = '{0, 0};

    always @(negedge clk) begin
        for (int g = 0; g < 2; g++) begin
            if (per_a[g] == 0) begin
                tones[g] = 1'b0;
                phase[g] = 0;
                use_b[g] = 1'b0;
            end else begin
                int cur;
                cur = use_b[g] ? per_b[g] : per_a[g];
                tones[g] = (phase[g] < cur / 2);
                phase[g]++;
                if (phase[g] >= cur) begin
                    phase[g] = 0;
                    if (per_b[g] != 0) use_b[g] = !use_b[g];
                end
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    int  freq_tab[8] = '{697, 770, 852, 941, 1209, 1336, 1477, 1633};
    int  key_tab[16] = '{1, 2, 3, 13, 4, 5, 6, 14, 7, 8, 9, 15, 11, 10, 12, 0};
    int  hq[2][4];
    int  hn[2];
    int  last_rise[2];
    bit  h1[2], h2[2], h3[2];
    bit  m_valid[2];
    int  m_idx[2];
    int  edge_no = 0;
    bit  exp_steer = 0;
    int  exp_code = 0;
    bit  started = 0;

    function automatic int match_window(input int g, input int sum);
        for (int k = 0; k < 4; k++) begin
            int n, lo, hi;
            n  = (4 * CLK_HZ) / freq_tab[g * 4 + k];
            lo = (n * 97) / 100;
            hi = (n * 103) / 100;
            if (sum >= lo && sum <= hi) return k;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            for (int g = 0; g < 2; g++) begin
                h1[g] = 0; h2[g] = 0; h3[g] = 0;
                hn[g] = 0; last_rise[g] = -1000000;
                m_valid[g] = 0;
            end
            exp_steer = 0;
        end else begin
            exp_steer = m_valid[0] && m_valid[1];
            exp_code  = key_tab[m_idx[0] * 4 + m_idx[1]];
            for (int g = 0; g < 2; g++) begin
                if (h2[g] && !h3[g]) begin
                    if (edge_no - last_rise[g] >= MAXC) begin
                        hn[g] = 0; m_valid[g] = 0;
                    end else begin
                        for (int i = 3; i > 0; i--) hq[g][i] = hq[g][i-1];
                        hq[g][0] = edge_no - last_rise[g];
                        if (hn[g] < 4) hn[g]++;
                        if (hn[g] == 4) begin
                            int k;
                            k = match_window(g, hq[g][0] + hq[g][1] + hq[g][2] + hq[g][3]);
                            m_valid[g] = (k >= 0);
                            if (k >= 0) m_idx[g] = k;
                        end else begin
                            m_valid[g] = 0;
                        end
                    end
                    last_rise[g] = edge_no;
                end else if (edge_no - last_rise[g] >= MAXC) begin
                    hn[g] = 0; m_valid[g] = 0;
                end
                h3[g] = h2[g]; h2[g] = h1[g]; h1[g] = tones[g];
            end
        end
        edge_no++;
    end

    // ---------------- per-cycle comparison ----------------
    bit seen_steer = 0;

    always @(negedge clk) begin
        if (started) begin
            n_tests++;
            if (early_steer !== exp_steer) begin
                n_fail++;
                $display("FAIL R1 R6 R7 cycle %0d: early_steer=%0b expected %0b",
                         edge_no, early_steer, exp_steer);
            end
            if (exp_steer) begin
                n_tests++;
                if (digit_code !== 4'(exp_code)) begin
                    n_fail++;
                    $display("FAIL R5 cycle %0d: digit_code=%0d expected %0d",
                             edge_no, digit_code, exp_code);
                end
            end
            if (early_steer === 1'b1) seen_steer = 1;
        end
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 200000) begin
            n_fail++;
            $display("FAIL watchdog: run exceeded cycle limit");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic play(input int la, input int lb, input int ha, input int hb, input int n);
        @(posedge clk);
        per_a[0] = la; per_b[0] = lb;
        per_a[1] = ha; per_b[1] = hb;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int lp[4], hp[4];
        for (int k = 0; k < 4; k++) begin
            lp[k] = CLK_HZ / freq_tab[k];
            hp[k] = CLK_HZ / freq_tab[4 + k];
        end
        repeat (4) @(negedge clk);
        chk("R8 steer low in reset", int'(early_steer), 0);
        rst = 1'b0;
        play(0, 0, 0, 0, 20);
        chk("R8 steer low after reset", int'(early_steer), 0);

        // all sixteen pairs
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                play(lp[r], 0, hp[c], 0, 1000);
                chk("R2 pair accepted", int'(early_steer), 1);
                chk("R5 key code", int'(digit_code), key_tab[r * 4 + c]);
                play(0, 0, 0, 0, 500);
                chk("R4 silence drops steer", int'(early_steer), 0);
            end

        // one band only
        play(0, 0, 82, 0, 600);
        chk("R1 high band alone", int'(early_steer), 0);
        // four rising edges = three periods
        seen_steer = 0;
        play(143, 0, 82, 0, 500);
        play(0, 0, 82, 0, 300);
        chk("R3 three periods rejected", int'(seen_steer), 0);
        play(143, 0, 82, 0, 643);
        chk("R3 four periods accepted", int'(early_steer), 1);

        // tolerance edges
        play(0, 0, 0, 0, 500);
        play(140, 0, 82, 0, 1000);
        chk("R2 low 2 percent fast accepted", int'(early_steer), 1);
        play(0, 0, 0, 0, 500);
        play(136, 0, 82, 0, 1000);
        chk("R2 low 5 percent fast rejected", int'(early_steer), 0);
        play(0, 0, 0, 0, 500);
        play(143, 0, 80, 0, 1000);
        chk("R2 high sum at window floor accepted", int'(early_steer), 1);
        chk("R5 code at window floor", int'(digit_code), 1);
        play(0, 0, 0, 0, 500);
        play(143, 0, 85, 0, 1000);
        chk("R2 high sum one above window rejected", int'(early_steer), 0);

        // averaging over alternating periods
        play(0, 0, 0, 0, 500);
        play(138, 148, 82, 0, 1500);
        chk("R9 alternating sum inside window", int'(early_steer), 1);
        play(0, 0, 0, 0, 500);
        play(120, 150, 82, 0, 1500);
        chk("R9 alternating sum outside windows", int'(early_steer), 0);

        // tone stops: saturation
        play(0, 0, 0, 0, 500);
        play(143, 0, 82, 0, 1000);
        chk("R4 steer before stop", int'(early_steer), 1);
        play(0, 0, 82, 0, 100);
        chk("R4 no early drop", int'(early_steer), 1);
        play(0, 0, 82, 0, 320);
        chk("R4 drop after saturation", int'(early_steer), 0);

        // out-of-window period
        play(143, 0, 82, 0, 1000);
        chk("R7 steer before change", int'(early_steer), 1);
        play(220, 0, 82, 0, 230);
        chk("R7 one long period drops steer", int'(early_steer), 0);

        // reset mid-tone
        play(143, 0, 82, 0, 1000);
        chk("R8 steer before reset", int'(early_steer), 1);
        @(negedge clk) rst = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 steer low during reset", int'(early_steer), 0);
        rst = 1'b0;
        repeat (300) @(negedge clk);
        chk("R8 history cleared by reset", int'(early_steer), 0);
        repeat (600) @(negedge clk);
        chk("R8 accepted again after four periods", int'(early_steer), 1);

        play(0, 0, 0, 0, 500);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule